// File: doc/BRIEF.md
# Character LCD Host Bus Slave Port

This block sits between a host processor's parallel bus and the core of a character display controller. The host drives a register-select line, a read/write line, an enable strobe and an eight-line data bus. The port brings these asynchronous signals into the core clock domain and detects the end of each enable pulse. It then issues a single strobe to the core for an instruction write, a data write or a data read, together with the byte that was written.

During a read, the port drives the bus. With select low it returns a status word: the busy flag on the top line and the address counter below it. With select high it returns the read data from the core. In nibble mode only the upper four lines carry information, and each byte takes two enable pulses, upper half first. A power-down input silences the port entirely.

Top module: `lcd_host_port`

## Requirements
- R1: A write (rw_i low) with select low produces exactly one one-cycle wr_inst_o pulse per completed byte, and byte_o then holds the written byte until the next completed write.
- R2: A write with select high produces exactly one one-cycle wr_data_o pulse per completed byte, with the byte on byte_o.
- R3: While a read is in progress, db_o carries core_rdata_i when select is high, or {core_busy_i, core_ac_i} when select is low (busy flag in bit 7). Only a completed data read (select high) pulses rd_data_o; a status read pulses nothing.
- R4: rw_i high selects a read and rw_i low selects a write; a read never changes byte_o.
- R5: Let j be the first core clock edge that samples en_i low after it was high. The strobe for that transfer is high for exactly the cycle after edge j+2.
- R6: In nibble mode (nib_mode_i high) a byte is written as two enable pulses. Bits 7:4 of the first pulse form the upper half and bits 7:4 of the second form the lower half, and bits 3:0 of the bus are ignored. A strobe follows only the second pulse.
- R7: In a nibble-mode read, db_o[7:4] carries bits 7:4 of the read word during the first pulse (the busy flag on bit 7 for status) and bits 3:0 during the second; db_o[3:0] is zero.
- R8: Any change of nib_mode_i returns the nibble phase to the upper half.
- R9: db_oe_o is high only while the synchronised enable is high with a read selected. It falls by the second clock edge that samples en_i low. db_o is zero whenever db_oe_o is low.
- R10: While pd_i is high no strobe is issued, the nibble phase does not advance and db_oe_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_i | input | 1 | Power-down, blocks all activity |
| nib_mode_i | input | 1 | 1 = four-line transfers, 0 = eight-line |
| rs_i | input | 1 | Register select, reads high when floating |
| rw_i | input | 1 | 1 = read, 0 = write, reads high when floating |
| en_i | input | 1 | Asynchronous transfer enable strobe |
| db_i | input | DW | Bus lines as seen at the pins |
| db_o | output | DW | Value driven onto the bus during reads |
| db_oe_o | output | 1 | Bus output enable |
| core_busy_i | input | 1 | Busy flag from the core |
| core_ac_i | input | DW-1 | Address counter from the core |
| core_rdata_i | input | DW | Read data from the core |
| wr_inst_o | output | 1 | Instruction write strobe |
| wr_data_o | output | 1 | Data write strobe |
| rd_data_o | output | 1 | Data read completed strobe |
| byte_o | output | DW | Last byte written by the host |

## Verification
The hardest state to reach is a nibble pair left half finished when the bus mode changes. If the phase were not cleared, the next upper nibble would be taken as a lower one and would complete a wrong byte. The stimulus sends one nibble-mode pulse and switches to eight-line mode while the bus is idle. It then switches back and sends a full pair. The behavioural model in the bench expects exactly one strobe, carrying the new pair's byte. Power-down is applied in the middle of the run so that any blocked strobe or advance of the phase would show up in the next transfers.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE    = 2'd0,
      ACC_INST_WR = 2'd1,
      ACC_DATA_WR = 2'd2,
      ACC_DATA_RD = 2'd3
   } acc_e;

   // undriven lines carry a pull-up: anything not a solid zero counts as one
   function automatic logic pull_high(input logic b);
      return (b === 1'b0) ? 1'b0 : 1'b1;
   endfunction

   function automatic acc_e classify(input logic rs, input logic rw);
      if (!rw)     return rs ? ACC_DATA_WR : ACC_INST_WR;
      else if (rs) return ACC_DATA_RD;
      else         return ACC_IDLE;
   endfunction

endpackage

// File: rtl/lcdp_sync.sv
module lcdp_sync #(
   parameter int W       = 1,
   parameter int STAGES  = 2,
   parameter bit RST_ONE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   if (STAGES < 2) begin : g_bad_stages
      $error("lcdp_sync: at least two stages are needed");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {(STAGES*W){RST_ONE}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/lcdp_xfer.sv
module lcdp_xfer #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pd,
   input  logic          nib_mode,
   input  logic          en_s,
   input  logic          rs_s,
   input  logic          rw_s,
   input  logic [DW-1:0] db_s,
   output logic          phase,
   output logic          wr_inst,
   output logic          wr_data,
   output logic          rd_data,
   output logic [DW-1:0] byte_q
);
   import lcdp_pkg::*;
   localparam int NIB = DW / 2;

   logic           en_q, mode_q, fall;
   logic [NIB-1:0] hi_q;
   acc_e           acc;

   assign fall = en_q & ~en_s & ~pd;
   assign acc  = classify(rs_s, rw_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         mode_q  <= nib_mode;
         phase   <= 1'b0;
         hi_q    <= '0;
         wr_inst <= 1'b0;
         wr_data <= 1'b0;
         rd_data <= 1'b0;
         byte_q  <= '0;
      end else begin
         en_q    <= en_s;
         mode_q  <= nib_mode;
         wr_inst <= 1'b0;
         wr_data <= 1'b0;
         rd_data <= 1'b0;
         if (nib_mode != mode_q) phase <= 1'b0;
         else if (fall)          phase <= nib_mode & ~phase;
         if (fall) begin
            if (nib_mode && !phase) begin
               if (!rw_s) hi_q <= db_s[DW-1 -: NIB];
            end else begin
               if (!rw_s) byte_q <= nib_mode ? {hi_q, db_s[DW-1 -: NIB]} : db_s;
               wr_inst <= (acc == ACC_INST_WR);
               wr_data <= (acc == ACC_DATA_WR);
               rd_data <= (acc == ACC_DATA_RD);
            end
         end
      end
   end

   a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_inst, wr_data, rd_data}));

   a_r1_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_inst | wr_data) |-> $stable(byte_q));

   a_r5_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_inst | wr_data | rd_data) |-> (!$past(en_s) && $past(en_s, 2)));

   a_r6_second_half: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_inst | wr_data) && nib_mode && $past(nib_mode) && $past(nib_mode, 2))
      |-> ($past(phase) && !phase));

   a_r10_pd_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pd) |-> !(wr_inst | wr_data | rd_data));
endmodule

// File: rtl/lcdp_drive.sv
module lcdp_drive #(
   parameter int DW = 8,
   parameter int AW = DW - 1
) (
   input  logic          pd,
   input  logic          nib_mode,
   input  logic          phase,
   input  logic          en_s,
   input  logic          rs_s,
   input  logic          rw_s,
   input  logic          core_busy,
   input  logic [AW-1:0] core_ac,
   input  logic [DW-1:0] core_rdata,
   output logic [DW-1:0] db_o,
   output logic          db_oe
);
   localparam int NIB = DW / 2;

   logic [DW-1:0]  word;
   logic [NIB-1:0] half;

   always_comb begin
      word  = rs_s ? core_rdata : {core_busy, core_ac};
      half  = phase ? word[NIB-1:0] : word[DW-1 -: NIB];
      db_oe = en_s & rw_s & ~pd;
      if (!db_oe)        db_o = '0;
      else if (nib_mode) db_o = {half, {NIB{1'b0}}};
      else               db_o = word;
   end
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port #(
   parameter int DW          = 8,
   parameter int AW          = DW - 1,
   parameter int SYNC_STAGES = 2,
   parameter bit NIB_SUPPORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pd_i,
   input  logic          nib_mode_i,
   input  logic          rs_i,
   input  logic          rw_i,
   input  logic          en_i,
   input  logic [DW-1:0] db_i,
   output logic [DW-1:0] db_o,
   output logic          db_oe_o,
   input  logic          core_busy_i,
   input  logic [AW-1:0] core_ac_i,
   input  logic [DW-1:0] core_rdata_i,
   output logic          wr_inst_o,
   output logic          wr_data_o,
   output logic          rd_data_o,
   output logic [DW-1:0] byte_o
);
   import lcdp_pkg::*;

   if (DW % 2 != 0) begin : g_bad_dw
      $error("lcd_host_port: DW must be even");
   end
   if (AW != DW - 1) begin : g_bad_aw
      $error("lcd_host_port: status word needs AW = DW-1");
   end

   logic          rs_c, rw_c, en_s, rs_s, rw_s, nib_mode, phase;
   logic [DW-1:0] db_c, db_s;

   always_comb begin
      rs_c = pull_high(rs_i);
      rw_c = pull_high(rw_i);
      for (int i = 0; i < DW; i++) db_c[i] = pull_high(db_i[i]);
   end

   if (NIB_SUPPORT) begin : g_nib
      assign nib_mode = nib_mode_i;
   end else begin : g_byte_only
      assign nib_mode = 1'b0;
   end

   lcdp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_sync_en (
      .clk(clk), .rst_n(rst_n), .d(en_i), .q(en_s));

   lcdp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n), .d({rs_c, rw_c}), .q({rs_s, rw_s}));

   lcdp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_sync_db (
      .clk(clk), .rst_n(rst_n), .d(db_c), .q(db_s));

   lcdp_xfer #(.DW(DW)) u_xfer (
      .clk(clk), .rst_n(rst_n), .pd(pd_i), .nib_mode(nib_mode),
      .en_s(en_s), .rs_s(rs_s), .rw_s(rw_s), .db_s(db_s),
      .phase(phase), .wr_inst(wr_inst_o), .wr_data(wr_data_o),
      .rd_data(rd_data_o), .byte_q(byte_o));

   lcdp_drive #(.DW(DW), .AW(AW)) u_drive (
      .pd(pd_i), .nib_mode(nib_mode), .phase(phase), .en_s(en_s),
      .rs_s(rs_s), .rw_s(rw_s), .core_busy(core_busy_i), .core_ac(core_ac_i),
      .core_rdata(core_rdata_i), .db_o(db_o), .db_oe(db_oe_o));

   a_r10_pd_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      pd_i |-> (!db_oe_o && db_o == '0));

   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |-> !db_oe_o);

   a_r9_write_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      (en_s && !rw_s) |-> !db_oe_o);
endmodule

// File: tb/tb_lcd_host_port.sv
`timescale 1ns/1ps
module tb_lcd_host_port;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       pd_i = 1'b0, nib_mode_i = 1'b0;
   logic       rs_i = 1'b1, rw_i = 1'b1, en_i = 1'b0;
   logic [7:0] db_i = 8'hFF;
   logic [7:0] db_o, byte_o, core_rdata_i = 8'h00;
   logic       db_oe_o, core_busy_i = 1'b0;
   logic [6:0] core_ac_i = 7'h00;
   logic       wr_inst_o, wr_data_o, rd_data_o;

   int total = 0, bad = 0;
   int n_wi = 0, n_wd = 0, n_rd = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lcd_host_port dut (
      .clk(clk), .rst_n(rst_n), .pd_i(pd_i), .nib_mode_i(nib_mode_i),
      .rs_i(rs_i), .rw_i(rw_i), .en_i(en_i), .db_i(db_i),
      .db_o(db_o), .db_oe_o(db_oe_o), .core_busy_i(core_busy_i),
      .core_ac_i(core_ac_i), .core_rdata_i(core_rdata_i),
      .wr_inst_o(wr_inst_o), .wr_data_o(wr_data_o), .rd_data_o(rd_data_o),
      .byte_o(byte_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: pin history per edge plus transfer state
   logic       h_en[4], h_rs[4], h_rw[4];
   logic [7:0] h_db[4];
   logic       m_phase, m_wi, m_wd, m_rd, m_mode_prev;
   logic [3:0] m_hi;
   logic [7:0] m_byte;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            h_en[i] = 1'b0; h_rs[i] = 1'b1; h_rw[i] = 1'b1; h_db[i] = 8'hFF;
         end
         m_phase = 1'b0; m_wi = 1'b0; m_wd = 1'b0; m_rd = 1'b0;
         m_hi = 4'h0; m_byte = 8'h00; m_mode_prev = nib_mode_i;
      end else begin
         bit fall, ph_old;
         for (int i = 3; i > 0; i--) begin
            h_en[i] = h_en[i-1]; h_rs[i] = h_rs[i-1];
            h_rw[i] = h_rw[i-1]; h_db[i] = h_db[i-1];
         end
         h_en[0] = en_i; h_rs[0] = rs_i; h_rw[0] = rw_i; h_db[0] = db_i;
         fall = h_en[3] && !h_en[2] && !pd_i;
         ph_old = m_phase;
         m_wi = 1'b0; m_wd = 1'b0; m_rd = 1'b0;
         if (nib_mode_i != m_mode_prev) m_phase = 1'b0;
         else if (fall && nib_mode_i)   m_phase = ~m_phase;
         m_mode_prev = nib_mode_i;
         if (fall) begin
            if (nib_mode_i && !ph_old) begin
               if (!h_rw[2]) m_hi = h_db[2][7:4];
            end else if (!h_rw[2]) begin
               m_byte = nib_mode_i ? {m_hi, h_db[2][7:4]} : h_db[2];
               m_wi = !h_rs[2]; m_wd = h_rs[2];
            end else begin
               m_rd = h_rs[2];
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic       e_oe;
         logic [7:0] w, e_db;
         e_oe = h_en[1] && h_rw[1] && !pd_i;
         w = h_rs[1] ? core_rdata_i : {core_busy_i, core_ac_i};
         if (!e_oe)           e_db = 8'h00;
         else if (nib_mode_i) e_db = {(m_phase ? w[3:0] : w[7:4]), 4'h0};
         else                 e_db = w;
         chk(wr_inst_o == m_wi, "R1 wr_inst model", wr_inst_o, m_wi);
         chk(wr_data_o == m_wd, "R2 wr_data model", wr_data_o, m_wd);
         chk(rd_data_o == m_rd, "R3 rd_data model", rd_data_o, m_rd);
         chk(db_oe_o == e_oe, "R9 db_oe model", db_oe_o, e_oe);
         chk(db_o == e_db, "R7 db_o model", db_o, e_db);
         chk(byte_o == m_byte, "R6 byte_o model", byte_o, m_byte);
         n_wi += int'(wr_inst_o); n_wd += int'(wr_data_o); n_rd += int'(rd_data_o);
      end
   end

   task automatic xfer(input logic rs, input logic rw, input logic [7:0] d,
                       output logic [7:0] seen, output logic oe);
      @(negedge clk); rs_i = rs; rw_i = rw; db_i = d;
      @(negedge clk); en_i = 1'b1;
      repeat (3) @(negedge clk);
      seen = db_o; oe = db_oe_o;
      @(negedge clk); en_i = 1'b0;
      repeat (6) @(negedge clk);
      rs_i = 1'b1; rw_i = 1'b1; db_i = 8'hFF;
   endtask

   task automatic set_mode(input logic m);
      @(negedge clk); nib_mode_i = m;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      logic [7:0] s;
      logic       o;
      int b_wi, b_wd, b_rd;
      repeat (3) @(negedge clk);
      chk(wr_inst_o == 0 && wr_data_o == 0 && rd_data_o == 0, "R1 reset strobes", 0, 0);
      chk(db_oe_o == 0, "R9 reset oe", db_oe_o, 0);
      chk(byte_o == 8'h00, "R1 reset byte", byte_o, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1/R4/R5: instruction write, eight lines
      b_wi = n_wi;
      xfer(1'b0, 1'b0, 8'hA5, s, o);
      chk(n_wi == b_wi + 1, "R1 one inst strobe", n_wi - b_wi, 1);
      chk(byte_o == 8'hA5, "R1 inst byte", byte_o, 8'hA5);
      chk(o == 1'b0, "R4 write leaves bus undriven", o, 0);

      // R2: data write
      b_wd = n_wd;
      xfer(1'b1, 1'b0, 8'h3C, s, o);
      chk(n_wd == b_wd + 1, "R2 one data strobe", n_wd - b_wd, 1);
      chk(byte_o == 8'h3C, "R2 data byte", byte_o, 8'h3C);

      // R3: data read
      core_rdata_i = 8'h5E; b_rd = n_rd;
      xfer(1'b1, 1'b1, 8'hFF, s, o);
      chk(s == 8'h5E && o, "R3 data read value", s, 8'h5E);
      chk(n_rd == b_rd + 1, "R3 read strobe", n_rd - b_rd, 1);
      chk(byte_o == 8'h3C, "R4 read keeps byte", byte_o, 8'h3C);

      // R3: status read, busy on bit 7
      core_busy_i = 1'b1; core_ac_i = 7'h2B; b_rd = n_rd;
      xfer(1'b0, 1'b1, 8'hFF, s, o);
      chk(s == 8'hAB, "R3 status word", s, 8'hAB);
      chk(n_rd == b_rd, "R3 status no strobe", n_rd - b_rd, 0);

      // R6: nibble write, low lines carry junk
      set_mode(1'b1); b_wi = n_wi;
      xfer(1'b0, 1'b0, 8'h9F, s, o);
      chk(n_wi == b_wi, "R6 no strobe after first half", n_wi - b_wi, 0);
      xfer(1'b0, 1'b0, 8'h65, s, o);
      chk(n_wi == b_wi + 1, "R6 strobe after second half", n_wi - b_wi, 1);
      chk(byte_o == 8'h96, "R6 assembled byte", byte_o, 8'h96);

      // R7: nibble status read {1,0x15} = 0x95
      core_ac_i = 7'h15;
      xfer(1'b0, 1'b1, 8'hFF, s, o);
      chk(s == 8'h90, "R7 upper half with busy", s, 8'h90);
      xfer(1'b0, 1'b1, 8'hFF, s, o);
      chk(s == 8'h50, "R7 lower half", s, 8'h50);

      // R8: half-done pair, then mode toggle, then full pair
      b_wd = n_wd;
      xfer(1'b1, 1'b0, 8'h3A, s, o);
      set_mode(1'b0);
      set_mode(1'b1);
      xfer(1'b1, 1'b0, 8'h70, s, o);
      chk(n_wd == b_wd, "R8 phase restarted", n_wd - b_wd, 0);
      xfer(1'b1, 1'b0, 8'hE0, s, o);
      chk(n_wd == b_wd + 1 && byte_o == 8'h7E, "R8 new pair byte", byte_o, 8'h7E);

      // R10: power-down in eight-line mode
      set_mode(1'b0);
      @(negedge clk); pd_i = 1'b1;
      b_wi = n_wi; b_rd = n_rd;
      xfer(1'b0, 1'b0, 8'h11, s, o);
      chk(n_wi == b_wi && byte_o == 8'h7E, "R10 write blocked", byte_o, 8'h7E);
      xfer(1'b1, 1'b1, 8'hFF, s, o);
      chk(o == 1'b0 && n_rd == b_rd, "R10 read undriven", o, 0);
      @(negedge clk); pd_i = 1'b0;

      // R10: phase untouched by blocked pulses in nibble mode
      set_mode(1'b1);
      @(negedge clk); pd_i = 1'b1;
      xfer(1'b0, 1'b0, 8'h40, s, o);
      @(negedge clk); pd_i = 1'b0;
      b_wi = n_wi;
      xfer(1'b0, 1'b0, 8'hC0, s, o);
      xfer(1'b0, 1'b0, 8'h30, s, o);
      chk(n_wi == b_wi + 1 && byte_o == 8'hC3, "R10 phase kept", byte_o, 8'hC3);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule